// File: doc/BRIEF.md
# Hot-Swap Fault Timer and Retry Sequencer

This block is the digital stand-in for the timing capacitor and restart logic of a hot-swap controller. A saturating counter plays the role of the capacitor voltage. It rises by a charge step on every clock while the current or power limiter is regulating, or while the short-circuit breaker is tripped. It falls by a fast step once the condition clears. When the counter reaches its upper threshold the block drops the pass switch and raises a one-cycle timeout pulse.

After a timeout the block behaves in one of two ways. In the first it latches off: the counter bleeds down at a slow step and the switch stays off until the enable input is dropped and raised again, with the counter already below the low threshold. In the second it runs a cooldown: the counter swings between the upper and middle thresholds, falling at the slow step and rising at the charge step. On the last falling ramp the counter continues down to the low threshold and the switch turns back on. A three-bit selector sets how many such retries are allowed before the block latches off; the choices are none, one, two, four, eight, sixteen or unlimited.

The breaker input also drives a fast gate pulldown, but only while the breaker stays tripped and the switch is on. Analog regulation and sensing sit outside this block.

Top module: `fault_retry_seq`

## Requirements
- R1: While the switch is on, enable is high and limit_act or brk_act is high, the timer rises by CHARGE_STEP each clock. Starting from a timer value t, the switch turns off on the ceil((HI_TH - t)/CHARGE_STEP)-th such clock.
- R2: While the switch is on and both fault inputs are low, the timer falls by FAST_STEP each clock, saturating at zero. No timeout occurs and the switch stays on.
- R3: In the clock where the timer would reach HI_TH, the timer is set to HI_TH and gate_on falls. fault_pd is high whenever gate_on is low, and timeout_pulse is high for exactly that one clock.
- R4: Once latched off, latched_off stays high and gate_on stays low for as long as enable stays high.
- R5: When enable returns high after being low, the switch turns on in the next clock if the timer is below LO_TH. Otherwise the block goes back to latched off. The timer falls by SLOW_STEP per clock while latched off or disabled.
- R6: A retry runs COOL_CYCLES falling ramps and COOL_CYCLES-1 rising ramps. Each fall goes from HI_TH to MID_TH at SLOW_STEP, and each rise goes from MID_TH to HI_TH at CHARGE_STEP. The last fall goes from HI_TH to LO_TH, after which the switch turns on with the timer at LO_TH. The off time is (COOL_CYCLES-1)*(ceil((HI-MID)/SLOW)+ceil((HI-MID)/CHARGE)) + ceil((HI-LO)/SLOW) clocks.
- R7: retry_sel sets the retry allowance. The encodings are 0 = none (latch off at the first timeout), 1 = 1, 2 = 2, 3 = 4, 4 = 8, 5 = 16, and 6 or 7 = unlimited. Timeout number allowance+1 latches off.
- R8: fast_pd is high exactly when brk_act is high and the switch is on. brk_act also charges the timer as in R1.
- R9: The used-retry count clears when the switch is on with both fault inputs low and the timer at zero, and also on a restart through enable.
- R10: The timer never exceeds HI_TH and never wraps below zero.
- R11: During reset gate_on, fast_pd, timeout_pulse and latched_off are low and the timer is zero. With enable high, the switch turns on one clock after reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; a low-then-high sequence restarts a latched-off block |
| limit_act | input | 1 | Current or power limiter is regulating |
| brk_act | input | 1 | Sensed level is above the breaker threshold |
| retry_sel | input | 3 | Retry allowance selector (encoding in R7) |
| gate_on | output | 1 | Pass switch drive on |
| fast_pd | output | 1 | Strong gate pulldown during a breaker trip |
| fault_pd | output | 1 | Holding gate pulldown while the switch is off |
| timeout_pulse | output | 1 | One-clock pulse at the end of a timeout |
| latched_off | output | 1 | Block is latched off waiting for a restart |

## Verification
The bench builds the block with thresholds 100/40/10 and steps 10/50/5. With these values a full timeout takes ten clocks, one retry cooldown takes 144 clocks, and a sixteen-retry run finishes within a few thousand clocks. That makes it practical to sweep every retry_sel encoding to exhaustion, and to sweep every fault length shorter than the timeout against a one-clock fast discharge. The small values also make the latch-off bleed to zero short enough to test restarts both above and below the low threshold, and both clearing paths of the retry count.

// File: rtl/fr_pkg.sv
// Package fr_pkg
// Shared types for the fault timer and retry sequencer: controller states
// and the operation codes the controller issues to the timer datapath.
package fr_pkg;

    typedef enum logic [2:0] {
        ST_OFF,     // enable low, switch off
        ST_ON,      // switch on, normal or limiting
        ST_LATCH,   // latched off, waiting for an enable cycle
        ST_CDN,     // cooldown, falling ramp
        ST_CUP      // cooldown, rising ramp
    } fr_state_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CHG,
        OP_FAST,
        OP_SLOW,
        OP_LD_HI,
        OP_LD_MID,
        OP_LD_LO
    } tmr_op_t;

endpackage

// File: rtl/fr_timer.sv
// Module fr_timer
// Saturating counter modelling the timing capacitor. Applies the operation
// chosen by the controller and reports where the next step would land
// relative to the three thresholds.
// Assumes HI_TH + CHARGE_STEP and MID_TH/LO_TH + SLOW_STEP fit in TW bits
// and that LO_TH < MID_TH < HI_TH.
module fr_timer
    import fr_pkg::*;
#(
    parameter int TW          = 16,
    parameter int HI_TH       = 3900,
    parameter int MID_TH      = 1200,
    parameter int LO_TH       = 300,
    parameter int CHARGE_STEP = 74,
    parameter int FAST_STEP   = 1500,
    parameter int SLOW_STEP   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_op_t       op,
    output logic [TW-1:0] tmr,
    output logic          reach_hi,
    output logic          reach_mid,
    output logic          reach_lo,
    output logic          below_lo,
    output logic          is_zero
);
    localparam int WW = TW + 1;
    localparam logic [WW-1:0] HI_W   = WW'(HI_TH);
    localparam logic [WW-1:0] MID_W  = WW'(MID_TH);
    localparam logic [WW-1:0] LO_W   = WW'(LO_TH);
    localparam logic [WW-1:0] CHG_W  = WW'(CHARGE_STEP);
    localparam logic [WW-1:0] FAST_W = WW'(FAST_STEP);
    localparam logic [WW-1:0] SLOW_W = WW'(SLOW_STEP);

    logic [WW-1:0] cur_w;
    logic [WW-1:0] up_w;
    logic [WW-1:0] fast_w;
    logic [WW-1:0] slow_w;
    logic [WW-1:0] nxt_w;

    // Candidate next values and threshold flags.
    always_comb begin
        cur_w     = {1'b0, tmr};
        up_w      = cur_w + CHG_W;
        fast_w    = (cur_w > FAST_W) ? (cur_w - FAST_W) : '0;
        slow_w    = (cur_w > SLOW_W) ? (cur_w - SLOW_W) : '0;
        reach_hi  = (up_w >= HI_W);
        reach_mid = (cur_w <= (MID_W + SLOW_W));
        reach_lo  = (cur_w <= (LO_W + SLOW_W));
        below_lo  = (cur_w < LO_W);
        is_zero   = (cur_w == '0);
    end

    // Select the next value from the requested operation.
    always_comb begin
        unique case (op)
            OP_CHG:    nxt_w = reach_hi ? HI_W : up_w;
            OP_FAST:   nxt_w = fast_w;
            OP_SLOW:   nxt_w = slow_w;
            OP_LD_HI:  nxt_w = HI_W;
            OP_LD_MID: nxt_w = MID_W;
            OP_LD_LO:  nxt_w = LO_W;
            default:   nxt_w = cur_w;
        endcase
    end

    // Timer register.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr <= '0;
        else        tmr <= nxt_w[TW-1:0];
    end

endmodule

// File: rtl/fr_retry.sv
// Module fr_retry
// Counts the retries used since the last recovery or restart and decodes
// the selector into an allowance. Codes from SEL_INF upward mean unlimited.
// Assumes the controller pulses inc only when it starts a retry.
module fr_retry #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    input  logic             inc,
    output logic             exhausted
);
    localparam int SEL_INF = (1 << SEL_W) - 2;
    localparam int CW      = SEL_INF - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] allow;
    logic          unlimited;

    // Decode the selector: 0 -> none, k -> 2^(k-1), top codes -> unlimited.
    always_comb begin
        unlimited = (int'(sel) >= SEL_INF);
        if (sel == '0 || unlimited) allow = '0;
        else                        allow = CW'(1) << (sel - SEL_W'(1));
        exhausted = !unlimited && (cnt >= allow);
    end

    // Used-retry counter, cleared on recovery or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (clr)                 cnt <= '0;
        else if (inc && !unlimited && !exhausted) cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/fr_ctrl.sv
// Module fr_ctrl
// Sequencer state machine. Chooses the timer operation each clock, tracks
// the cooldown ramp index and drives the switch and status outputs.
// Assumes the timer flags describe the value held in the current clock.
module fr_ctrl
    import fr_pkg::*;
#(
    parameter int COOL_CYCLES = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    limit_act,
    input  logic    brk_act,
    input  logic    reach_hi,
    input  logic    reach_mid,
    input  logic    reach_lo,
    input  logic    below_lo,
    input  logic    is_zero,
    input  logic    exhausted,
    output tmr_op_t op,
    output logic    rc_clr,
    output logic    rc_inc,
    output logic    gate_on,
    output logic    fast_pd,
    output logic    fault_pd,
    output logic    timeout_pulse,
    output logic    latched_off
);
    localparam int CYW = $clog2(COOL_CYCLES + 1);
    localparam logic [CYW-1:0] LAST_CYC = CYW'(COOL_CYCLES);

    fr_state_t      state, state_n;
    logic [CYW-1:0] cyc, cyc_n;
    logic           tout_n;
    logic           fault;

    // Next state, timer operation and retry-count control.
    always_comb begin
        fault   = limit_act || brk_act;
        state_n = state;
        cyc_n   = cyc;
        op      = OP_SLOW;
        rc_clr  = 1'b0;
        rc_inc  = 1'b0;
        tout_n  = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (en) begin
                    if (below_lo) begin
                        state_n = ST_ON;
                        rc_clr  = 1'b1;
                    end else begin
                        state_n = ST_LATCH;
                    end
                end
            end
            ST_ON: begin
                if (!en) begin
                    state_n = ST_OFF;
                end else if (fault) begin
                    if (reach_hi) begin
                        op     = OP_LD_HI;
                        tout_n = 1'b1;
                        if (exhausted) begin
                            state_n = ST_LATCH;
                        end else begin
                            state_n = ST_CDN;
                            cyc_n   = CYW'(1);
                            rc_inc  = 1'b1;
                        end
                    end else begin
                        op = OP_CHG;
                    end
                end else begin
                    op     = OP_FAST;
                    rc_clr = is_zero;
                end
            end
            ST_LATCH: begin
                if (!en) state_n = ST_OFF;
            end
            ST_CDN: begin
                if (!en) begin
                    state_n = ST_OFF;
                end else if (cyc == LAST_CYC) begin
                    if (reach_lo) begin
                        op      = OP_LD_LO;
                        state_n = ST_ON;
                    end
                end else if (reach_mid) begin
                    op      = OP_LD_MID;
                    state_n = ST_CUP;
                end
            end
            ST_CUP: begin
                if (!en) begin
                    state_n = ST_OFF;
                end else if (reach_hi) begin
                    op      = OP_LD_HI;
                    state_n = ST_CDN;
                    cyc_n   = cyc + CYW'(1);
                end else begin
                    op = OP_CHG;
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    // State, ramp index and timeout pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_OFF;
            cyc           <= '0;
            timeout_pulse <= 1'b0;
        end else begin
            state         <= state_n;
            cyc           <= cyc_n;
            timeout_pulse <= tout_n;
        end
    end

    // Switch drive and status decode.
    always_comb begin
        gate_on     = (state == ST_ON);
        fast_pd     = gate_on && brk_act;
        fault_pd    = !gate_on;
        latched_off = (state == ST_LATCH);
    end

endmodule

// File: rtl/fault_retry_seq.sv
// Module fault_retry_seq
// Top level of the fault timer and retry sequencer: joins the timer
// datapath, the retry counter and the sequencer state machine.
// Assumes synchronous inputs and parameters given in timer counts.
module fault_retry_seq
    import fr_pkg::*;
#(
    parameter int TW          = 16,
    parameter int HI_TH       = 3900,
    parameter int MID_TH      = 1200,
    parameter int LO_TH       = 300,
    parameter int CHARGE_STEP = 74,
    parameter int FAST_STEP   = 1500,
    parameter int SLOW_STEP   = 3,
    parameter int COOL_CYCLES = 8,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             limit_act,
    input  logic             brk_act,
    input  logic [SEL_W-1:0] retry_sel,
    output logic             gate_on,
    output logic             fast_pd,
    output logic             fault_pd,
    output logic             timeout_pulse,
    output logic             latched_off
);
    tmr_op_t       op;
    logic [TW-1:0] tmr_val;
    logic          reach_hi, reach_mid, reach_lo, below_lo, is_zero;
    logic          rc_clr, rc_inc, exhausted;

    fr_timer #(
        .TW(TW), .HI_TH(HI_TH), .MID_TH(MID_TH), .LO_TH(LO_TH),
        .CHARGE_STEP(CHARGE_STEP), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .op(op), .tmr(tmr_val),
        .reach_hi(reach_hi), .reach_mid(reach_mid), .reach_lo(reach_lo),
        .below_lo(below_lo), .is_zero(is_zero)
    );

    fr_retry #(.SEL_W(SEL_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .sel(retry_sel),
        .clr(rc_clr), .inc(rc_inc), .exhausted(exhausted)
    );

    fr_ctrl #(.COOL_CYCLES(COOL_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .limit_act(limit_act),
        .brk_act(brk_act), .reach_hi(reach_hi), .reach_mid(reach_mid),
        .reach_lo(reach_lo), .below_lo(below_lo), .is_zero(is_zero),
        .exhausted(exhausted), .op(op), .rc_clr(rc_clr), .rc_inc(rc_inc),
        .gate_on(gate_on), .fast_pd(fast_pd), .fault_pd(fault_pd),
        .timeout_pulse(timeout_pulse), .latched_off(latched_off)
    );

endmodule

// File: rtl/fr_checker.sv
// Module fr_checker
// Property checker bound to fault_retry_seq. Watches the ports and the
// timer value and checks the timing and ramp rules.
// Assumes the same parameters as the instance it is bound to.
module fr_checker #(
    parameter int TW          = 16,
    parameter int HI_TH       = 3900,
    parameter int CHARGE_STEP = 74,
    parameter int FAST_STEP   = 1500
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          limit_act,
    input logic          brk_act,
    input logic          gate_on,
    input logic          fast_pd,
    input logic          timeout_pulse,
    input logic          latched_off,
    input logic [TW-1:0] tmr
);
    localparam logic [TW-1:0] HI_V   = TW'(HI_TH);
    localparam logic [TW-1:0] CHG_V  = TW'(CHARGE_STEP);
    localparam logic [TW-1:0] FAST_V = TW'(FAST_STEP);

    p_charge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && en && (limit_act || brk_act))
        |=> ((tmr == HI_V) || (tmr == $past(tmr) + CHG_V)));

    p_fast_dis_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && en && !limit_act && !brk_act)
        |=> (tmr == (($past(tmr) > FAST_V) ? ($past(tmr) - FAST_V) : '0)));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    p_pulse_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (!gate_on && $past(gate_on) && (tmr == HI_V)));

    p_latch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && en) |=> (latched_off && !gate_on));

    p_fastpd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fast_pd |-> brk_act);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= HI_V);

    p_latch_bleed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && en) |=> (tmr <= $past(tmr)));

endmodule

bind fault_retry_seq fr_checker #(
    .TW(TW), .HI_TH(HI_TH), .CHARGE_STEP(CHARGE_STEP), .FAST_STEP(FAST_STEP)
) u_fr_checker (
    .clk(clk), .rst_n(rst_n), .en(en), .limit_act(limit_act),
    .brk_act(brk_act), .gate_on(gate_on), .fast_pd(fast_pd),
    .timeout_pulse(timeout_pulse), .latched_off(latched_off), .tmr(tmr_val)
);

// File: tb/tb_fault_retry_seq.sv
// Bench for fault_retry_seq: small thresholds, sweeps of the retry selector
// and the fault length, expected timings computed from the requirements.
module tb_fault_retry_seq;
    localparam int HI = 100, MID = 40, LO = 10;
    localparam int CH = 10, FA = 50, SL = 5, CC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       limit_act = 1'b0;
    logic       brk_act = 1'b0;
    logic [2:0] retry_sel = 3'd0;
    logic       gate_on, fast_pd, fault_pd, timeout_pulse, latched_off;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fault_retry_seq #(
        .TW(16), .HI_TH(HI), .MID_TH(MID), .LO_TH(LO),
        .CHARGE_STEP(CH), .FAST_STEP(FA), .SLOW_STEP(SL),
        .COOL_CYCLES(CC), .SEL_W(3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .limit_act(limit_act),
        .brk_act(brk_act), .retry_sel(retry_sel), .gate_on(gate_on),
        .fast_pd(fast_pd), .fault_pd(fault_pd),
        .timeout_pulse(timeout_pulse), .latched_off(latched_off)
    );

    function automatic int cdiv(int a, int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int on_len(int t0);
        return cdiv(HI - t0, CH) - 1;
    endfunction

    function automatic int off_len();
        return (CC - 1) * (cdiv(HI - MID, SL) + cdiv(HI - MID, CH)) + cdiv(HI - LO, SL);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [2:0] sel);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; limit_act = 1'b0; brk_act = 1'b0;
        retry_sel = sel;
        repeat (3) @(negedge clk);
        chk(!gate_on && !fast_pd && !timeout_pulse && !latched_off && fault_pd,
            "R11 reset outputs", {gate_on, fast_pd, timeout_pulse, latched_off, fault_pd}, 1);
        rst_n = 1'b1; en = 1'b1;
        @(negedge clk);
        chk(gate_on, "R11 on after reset", gate_on, 1);
    endtask

    // Counts further on samples; returns at the first off sample.
    task automatic count_on(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (!gate_on) break;
            n++;
        end
    endtask

    // Counts off samples including the current one; returns at first on.
    task automatic count_off(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (gate_on) break;
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int n;
        int allow;
        int runs;
        int t;
        // R7/R6/R3 sweep of every selector code
        for (int s = 0; s < 7; s++) begin
            do_reset(3'(s));
            allow = (s == 0) ? 0 : (1 << (s - 1));
            runs  = (s == 6) ? 20 : allow;
            limit_act = 1'b1;
            for (int i = 0; i <= runs; i++) begin
                count_on(n);
                chk(n == ((i == 0) ? on_len(0) : on_len(LO)), "R1 on time", n,
                    (i == 0) ? on_len(0) : on_len(LO));
                chk(timeout_pulse && fault_pd, "R3 timeout pulse", timeout_pulse, 1);
                if (i < allow || s == 6) begin
                    chk(!latched_off, "R7 retry granted", latched_off, 0);
                    if (i == runs) break;
                    count_off(n);
                    chk(n == off_len(), "R6 cooldown length", n, off_len());
                end else begin
                    chk(latched_off, "R7 exhausted latches", latched_off, 1);
                    @(negedge clk);
                    chk(!timeout_pulse, "R3 pulse one clock", timeout_pulse, 0);
                    repeat (4) @(negedge clk);
                    chk(latched_off && !gate_on, "R4 latch holds", latched_off, 1);
                end
            end
        end

        // R2 sweep of fault lengths below the timeout, one fast step between
        for (int k = 1; k < cdiv(HI, CH); k++) begin
            do_reset(3'd0);
            limit_act = 1'b1;
            for (int j = 0; j < k; j++) begin
                @(negedge clk);
                chk(gate_on && !timeout_pulse, "R2 short fault keeps on", gate_on, 1);
            end
            limit_act = 1'b0;
            @(negedge clk);
            chk(gate_on, "R2 on after clear", gate_on, 1);
            limit_act = 1'b1;
            t = (CH * k > FA) ? CH * k - FA : 0;
            count_on(n);
            chk(n == on_len(t), "R2 fast discharge", n, on_len(t));
        end

        // R8 breaker pulldown and charging, retry_sel 0
        do_reset(3'd0);
        brk_act = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(fast_pd && gate_on, "R8 fast pulldown", fast_pd, 1);
        end
        brk_act = 1'b0;
        @(negedge clk);
        chk(!fast_pd && gate_on, "R8 pulldown released", fast_pd, 0);
        brk_act = 1'b1;
        count_on(n);
        chk(n == on_len(0), "R8 breaker charges timer", n, on_len(0));
        chk(!fast_pd && latched_off, "R8 no fast pulldown when off", fast_pd, 0);

        // R5 restart attempt with timer above LO stays latched
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(latched_off && !gate_on, "R5 restart refused", gate_on, 0);
        brk_act = 1'b0;
        repeat (40) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(gate_on && !latched_off, "R5 restart accepted", gate_on, 1);

        // R9 re-enable clears the retry count, R10 timer bled to zero
        do_reset(3'd1);
        limit_act = 1'b1;
        count_on(n);
        count_off(n);
        count_on(n);
        chk(latched_off, "R7 one retry then latch", latched_off, 1);
        repeat (40) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(gate_on, "R5 restart after bleed", gate_on, 1);
        count_on(n);
        chk(n == on_len(0), "R10 timer saturated at zero", n, on_len(0));
        chk(!latched_off, "R9 re-enable clears count", latched_off, 1'b0);

        // R9 recovery clears the retry count
        do_reset(3'd1);
        limit_act = 1'b1;
        count_on(n);
        count_off(n);
        limit_act = 1'b0;
        repeat (2) @(negedge clk);
        limit_act = 1'b1;
        count_on(n);
        chk(n == on_len(0), "R2 recovered to zero", n, on_len(0));
        chk(!latched_off, "R9 recovery clears count", latched_off, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule